// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a single-port synchronous SRAM with a four-beat burst engine. It holds words of four 9-bit lanes (8 data bits plus one parity bit each, 36 bits in all). Every control input is sampled on the rising clock edge. An address strobe loads a new line address and a 2-bit start offset. The advance input then steps the offset through a four-beat burst or holds it in place.

Two address strobes are provided. The processor strobe has priority and is honoured only while the first chip enable is asserted. The controller strobe loads whenever the processor strobe is not taken. Each beat can write all lanes at once or only selected lanes. A write on the processor strobe's load cycle is dropped. Read data comes straight from the array at the registered beat address, so it appears in the same cycle the address is registered. The data output is enabled only while output enable is low and the block is selected. It stays disabled for the first cycle after the block leaves the deselected state. While the sleep input is high, the block ignores all accesses and keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: On a rising edge with sleep low, the address is captured and the beat index cleared when the controller strobe is low, or when the processor strobe and the first enable are both low; with neither, the address and beat are held.
- R2: When both strobes are low and the first enable is low, the processor strobe is the one taken, so the write inputs of that cycle are dropped.
- R3: The processor strobe has no effect while the first enable is high; if the controller strobe is also high, the burst state is unchanged.
- R4: A load selects the block only if ce1_n is low, ce2 is high and ce3_n is low. A deselected block drives dq_oe low and performs no writes. The enables are ignored on cycles without a load.
- R5: In linear mode (BURST_XOR=0), each cycle with advance low and the block selected moves the beat address to base+k modulo 4 within the line. After four advances it is back at the loaded offset.
- R6: With advance high and no load, the beat address is held (suspend).
- R7: With gw_n low, all four lanes of the current beat address take dq_in, whatever bwe_n and bw_n are.
- R8: With gw_n high, lane i (dq_in bits 9i+8..9i) is written only when bwe_n is low and bw_n[i] is low.
- R9: A write on a controller-strobe load cycle goes to the newly loaded address. A write on a processor-strobe load cycle is ignored, and writes on the following cycles take effect.
- R10: After each edge, dq_out shows the word at the registered beat address whenever dq_oe is high. dq_oe is high only with oe_n low, the block selected and sleep low; otherwise dq_out is zero.
- R11: On the first cycle after a load turns a deselected block into a selected one, dq_oe is low even with oe_n low.
- R12: While zz is high, no state changes, no write occurs and dq_oe is low. zz may rise only while the block is deselected.
- R13: With BURST_XOR=1, the beat offset is the loaded offset XOR the advance count (offset 1 gives 1,0,3,2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control state |
| addr | input | AW | Word address; bits [1:0] are the burst start offset |
| ce1_n | input | 1 | First chip enable, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Second chip enable, active high |
| ce3_n | input | 1 | Third chip enable, active low |
| adsp_n | input | 1 | Processor address strobe, active low, priority |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write of all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low |
| zz | input | 1 | Sleep, active high |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data, zero when not driven |
| dq_oe | output | 1 | High when dq_out drives the bus |

## Verification
Some properties are checked on every cycle: address capture on a load, holding on suspend, wrap of the beat index from 3 to 0, the freeze during sleep, sleep entry only while deselected, and the blank output on the first selected cycle and while deselected. Other behaviour shows up only in the data, so only the bench scenarios can show it. That covers strobe priority seen as a dropped write, lane masking, writes dropped while deselected or asleep, linear versus XOR burst order, and read-after-write at the registered beat address. Those scenarios compare against a reference memory held in the bench.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH     = 1024,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter bit BURST_XOR = 1'b0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [$clog2(DEPTH)-1:0]        addr,
  input  logic                            ce1_n,
  input  logic                            ce2,
  input  logic                            ce3_n,
  input  logic                            adsp_n,
  input  logic                            adsc_n,
  input  logic                            adv_n,
  input  logic                            gw_n,
  input  logic                            bwe_n,
  input  logic [LANES-1:0]                bw_n,
  input  logic                            oe_n,
  input  logic                            zz,
  input  logic [LANES*LANE_W-1:0]         dq_in,
  output logic [LANES*LANE_W-1:0]         dq_out,
  output logic                            dq_oe
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW - 2;
  localparam int DW = LANES * LANE_W;

  logic [DW-1:0] mem [DEPTH];

  logic          sel_q, mask_q;
  logic [LW-1:0] line_q;
  logic [1:0]    base_q, beat_q;

  logic          p_ld, c_ld, ld, en_hit, sel_nx, do_wr;
  logic [LW-1:0] line_nx;
  logic [1:0]    base_nx, beat_nx, cur_low, nx_low;
  logic [LANES-1:0] wr_lanes;

  assign p_ld   = !adsp_n && !ce1_n;
  assign c_ld   = !adsc_n && !p_ld;
  assign ld     = p_ld || c_ld;
  assign en_hit = !ce1_n && ce2 && !ce3_n;

  assign sel_nx  = ld ? en_hit : sel_q;
  assign line_nx = ld ? addr[AW-1:2] : line_q;
  assign base_nx = ld ? addr[1:0] : base_q;
  assign beat_nx = ld ? 2'd0 : ((sel_q && !adv_n) ? beat_q + 2'd1 : beat_q);

  generate
    if (BURST_XOR) begin : g_xor
      assign cur_low = base_q ^ beat_q;
      assign nx_low  = base_nx ^ beat_nx;
    end else begin : g_lin
      assign cur_low = base_q + beat_q;
      assign nx_low  = base_nx + beat_nx;
    end
  endgenerate

  assign wr_lanes = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  assign do_wr    = !zz && sel_nx && !p_ld && (|wr_lanes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      mask_q <= 1'b0;
      line_q <= '0;
      base_q <= 2'd0;
      beat_q <= 2'd0;
    end else if (!zz) begin
      sel_q  <= sel_nx;
      mask_q <= ld && en_hit && !sel_q;
      line_q <= line_nx;
      base_q <= base_nx;
      beat_q <= beat_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      for (int i = 0; i < LANES; i++) begin
        if (wr_lanes[i]) mem[{line_nx, nx_low}][i*LANE_W +: LANE_W] <= dq_in[i*LANE_W +: LANE_W];
      end
    end
  end

  assign dq_oe  = sel_q && !oe_n && !mask_q && !zz;
  assign dq_out = dq_oe ? mem[{line_q, cur_low}] : '0;

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && (!adsc_n || (!adsp_n && !ce1_n))) |=>
      (line_q == $past(addr[AW-1:2]) && base_q == $past(addr[1:0]) && beat_q == 2'd0));

  assert_suspend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && adsc_n && (adsp_n || ce1_n) && adv_n) |=>
      ($stable(beat_q) && $stable(line_q) && $stable(sel_q)));

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!zz && adsc_n && (adsp_n || ce1_n) && !adv_n && sel_q && beat_q == 2'd3) |=>
      (beat_q == 2'd0));

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !dq_oe);

  assert_first_read_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_q) |-> !dq_oe);

  assert_sleep_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
    zz |=> ($stable(sel_q) && $stable(beat_q) && $stable(line_q) && $stable(base_q)));

  assert_sleep_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zz) |-> !sel_q);
endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] a;
  logic c1n, c2, c3n, pn, cn, vn, gn, ben, on, z;
  logic [3:0] bwn;
  logic [DW-1:0] din;
  logic [DW-1:0] dq_out, dqx_out;
  logic dq_oe, dqx_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] mm [DEPTH];
  logic msel = 1'b0, mmask = 1'b0;
  logic [AW-3:0] mline = '0;
  logic [1:0] mbase = 2'd0, mbeat = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_sram #(.DEPTH(DEPTH)) i_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(a), .ce1_n(c1n), .ce2(c2), .ce3_n(c3n),
    .adsp_n(pn), .adsc_n(cn), .adv_n(vn), .gw_n(gn), .bwe_n(ben), .bw_n(bwn),
    .oe_n(on), .zz(z), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe));

  sync_burst_sram #(.DEPTH(DEPTH), .BURST_XOR(1'b1)) i_sync_burst_sram_x (
    .clk(clk), .rst_n(rst_n), .addr(a), .ce1_n(c1n), .ce2(c2), .ce3_n(c3n),
    .adsp_n(pn), .adsc_n(cn), .adv_n(vn), .gw_n(gn), .bwe_n(ben), .bw_n(bwn),
    .oe_n(on), .zz(z), .dq_in(din), .dq_out(dqx_out), .dq_oe(dqx_oe));

  function automatic logic [DW-1:0] word(input int n);
    logic [31:0] v;
    v = 32'h5a3c_0000 ^ (n * 32'h0001_0203);
    return {n[3:0] ^ 4'h9, v};
  endfunction

  function automatic logic [AW-1:0] maddr();
    return {mline, mbase + mbeat};
  endfunction

  task automatic idle();
    pn = 1; cn = 1; vn = 1; gn = 1; ben = 1; bwn = 4'hf; on = 0; z = 0;
    c1n = 0; c2 = 1; c3n = 0;
  endtask

  task automatic model();
    logic p, c, ld, nsel;
    logic [3:0] lanes;
    if (z) return;
    p = !pn && !c1n;
    c = !cn && !p;
    ld = p || c;
    nsel = !c1n && c2 && !c3n;
    if (ld) begin
      mmask = nsel && !msel;
      msel = nsel;
      mline = a[AW-1:2];
      mbase = a[1:0];
      mbeat = 2'd0;
    end else begin
      mmask = 1'b0;
      if (msel && !vn) mbeat = mbeat + 2'd1;
    end
    lanes = !gn ? 4'hf : (!ben ? ~bwn : 4'h0);
    if (msel && !p) begin
      for (int i = 0; i < 4; i++)
        if (lanes[i]) mm[maddr()][i*9 +: 9] = din[i*9 +: 9];
    end
  endtask

  task automatic check(input string tag);
    logic eoe;
    eoe = msel && !on && !mmask && !z;
    checks++;
    if (dq_oe !== eoe) begin
      errors++;
      $display("FAIL %s dq_oe actual %b expected %b", tag, dq_oe, eoe);
    end
    if (eoe) begin
      checks++;
      if (dq_out !== mm[maddr()]) begin
        errors++;
        $display("FAIL %s dq_out actual %h expected %h", tag, dq_out, mm[maddr()]);
      end
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    check(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1bad_5eed));
    idle(); a = '0; din = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin errors++; $display("FAIL R10 reset dq_oe actual %b expected 0", dq_oe); end
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 after reset");

    for (int n = 0; n < DEPTH; n++) begin
      idle(); cn = 0; gn = 0; a = AW'(n); din = word(n);
      step("R7 fill");
    end

    idle(); cn = 0; a = 6'd13; step("R13 load");
    for (int k = 0; k < 4; k++) begin
      if (k > 0) begin idle(); vn = 0; step("R5 linear beside R13"); end
      checks++;
      if (dqx_out !== mm[{4'd3, 2'(1 ^ k)}]) begin
        errors++;
        $display("FAIL R13 beat %0d actual %h expected %h", k, dqx_out, mm[{4'd3, 2'(1 ^ k)}]);
      end
    end

    idle(); cn = 0; a = 6'd6; step("R1 load");
    for (int k = 0; k < 4; k++) begin idle(); vn = 0; step("R5 burst"); end
    checks++;
    if (maddr() !== 6'd6) begin errors++; $display("FAIL R5 wrap actual %0d expected 6", maddr()); end
    idle(); step("R6 suspend"); step("R6 suspend");

    idle(); pn = 0; cn = 0; gn = 0; a = 6'd20; din = 36'h0; step("R2 both strobes");
    idle(); step("R2 word kept");

    idle(); pn = 0; gn = 0; a = 6'd21; din = 36'h1_2345_6789; step("R9 processor load");
    idle(); gn = 0; din = 36'h1_2345_6789; step("R9 next cycle write");
    idle(); cn = 0; gn = 0; a = 6'd22; din = 36'h8_7654_3210; step("R9 controller write");

    idle(); cn = 0; a = 6'd24; step("R3 load");
    idle(); pn = 0; c1n = 1; a = 6'd40; step("R3 processor ignored");

    idle(); cn = 0; c2 = 0; gn = 0; a = 6'd30; din = 36'h0; step("R4 deselected write");
    idle(); cn = 0; a = 6'd30; step("R11 first cycle masked");
    idle(); step("R4 word kept");

    idle(); cn = 0; a = 6'd33; ben = 0; bwn = 4'b1010; din = 36'hf_ffff_ffff; step("R8 lanes 0 and 2");
    idle(); cn = 0; a = 6'd35; ben = 1; bwn = 4'b0000; din = 36'h0; step("R8 no lane enable");
    idle(); cn = 0; a = 6'd34; gn = 0; ben = 1; bwn = 4'hf; din = 36'h3_0f0f_0f0f; step("R7 all lanes");
    idle(); on = 1; step("R10 output disabled");

    idle(); cn = 0; c2 = 0; step("R12 deselect");
    for (int k = 0; k < 3; k++) begin
      idle(); z = 1; cn = 0; gn = 0; a = 6'd36; din = 36'h0; step("R12 asleep");
    end
    idle(); step("R12 wake");
    idle(); cn = 0; a = 6'd36; step("R12 reselect");
    idle(); step("R12 contents kept");

    for (int n = 0; n < 4000; n++) begin
      logic zn;
      zn = z ? (($urandom % 4) != 0) : (!msel && ($urandom % 25) == 0);
      a   = AW'($urandom);
      pn  = ($urandom % 5) != 0;
      cn  = ($urandom % 5) != 0;
      c1n = ($urandom % 6) == 0;
      c2  = ($urandom % 8) != 0;
      c3n = ($urandom % 8) == 0;
      vn  = ($urandom % 2) != 0;
      gn  = ($urandom % 7) != 0;
      ben = ($urandom % 3) != 0;
      bwn = 4'($urandom);
      on  = ($urandom % 4) == 0;
      din = {4'($urandom), 32'($urandom)};
      z   = zn;
      step("R10 random");
    end
    finish_run();
  end
endmodule